// File: doc/BRIEF.md
# Two-Dimensional Transfer Sequencer with Line Watermark

This block is the job controller of a two-dimensional pixel mover. Software writes a start bit. The sequencer then walks a rectangle one line at a time and one pixel at a time. For each pixel it tells a datapath when to issue a write beat and which line and pixel that beat belongs to. The same sequencer can run an automatic lookup-table load instead of a pixel rectangle. A table load is a single run of entries and uses the same controls.

While a job runs, software can freeze it with a suspend level. A frozen job keeps its position and can either resume or be cancelled. An abort pulse cancels a running or frozen job outright. A cancelled job never reports completion. A normally finished job sets a sticky completion flag. A programmable line number sets a second sticky flag when the final pixel of that line is written. Each flag drives an interrupt output through its own enable. Both flags are cleared by write-one-to-clear pulses.

Top module: `xfer2d_seq`

## Requirements
- R1: A `start_set` pulse while idle makes `start_bit` and `busy` high after the next clock edge. The clock edge that issues the final beat clears `start_bit` and sets `tc_flag`. `busy` falls one cycle after that edge.
- R2: `tc_irq` is high exactly when `tc_flag` is set and `tc_ie` is high.
- R3: No beat is issued in any cycle in which `susp_req` is high. After the next edge `dp_hold` is high. While held, `beat_line` and `beat_pix` keep their values. Dropping `susp_req` resumes at the same pixel, and the beat count is unchanged.
- R4: An `abort_set` pulse while a job is running or frozen issues no beat in that cycle. It clears `start_bit` and `busy` at the next edge, and `tc_flag` stays clear.
- R5: With `lut_job` high, the job is one line of `lut_count` beats on line 0. Suspend and abort act on it as on pixel jobs, and it sets `tc_flag` but never `wm_flag`.
- R6: Beats are issued only in cycles where `beat_ready` is high and the job is running. They go in raster order: pixels 0 to `line_pixels`-1 of line 0, then line 1, and so on up to line `num_lines`-1. `beat_eol` marks the last pixel of every line.
- R7: Lines are numbered from 0. `wm_flag` sets at the edge of the beat for line `wm_line`, pixel `line_pixels`-1. It never sets when `wm_line` >= `num_lines`.
- R8: `wm_irq` is high exactly when `wm_flag` is set and `wm_ie` is high.
- R9: Both flags stay set until their clear pulse (`clr_tc`, `clr_wm`). If a set and a clear fall in the same cycle, the set wins. Starting a new job leaves earlier flags untouched.
- R10: A `start_set` pulse during a job has no effect on its beats or its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_set | input | 1 | Software write of the start bit |
| susp_req | input | 1 | Suspend level |
| abort_set | input | 1 | Abort pulse |
| lut_job | input | 1 | Job is a lookup-table load |
| num_lines | input | 16 | Lines in the rectangle |
| line_pixels | input | 14 | Pixels per line |
| lut_count | input | 8 | Table entries to load |
| wm_line | input | 16 | Watermark line number |
| tc_ie | input | 1 | Completion interrupt enable |
| wm_ie | input | 1 | Watermark interrupt enable |
| clr_tc | input | 1 | Clear completion flag |
| clr_wm | input | 1 | Clear watermark flag |
| beat_ready | input | 1 | Datapath can take a beat |
| beat_go | output | 1 | Issue a write beat this cycle |
| beat_line | output | 16 | Line of current beat |
| beat_pix | output | 14 | Pixel of current beat |
| beat_eol | output | 1 | Current beat ends a line |
| dp_hold | output | 1 | Job is frozen |
| start_bit | output | 1 | Start bit readback |
| busy | output | 1 | Sequencer not idle |
| tc_flag | output | 1 | Sticky completion flag |
| wm_flag | output | 1 | Sticky watermark flag |
| tc_irq | output | 1 | Completion interrupt |
| wm_irq | output | 1 | Watermark interrupt |

## Verification
Two pairs of events can land in the same cycle. In the first, an abort or a suspend arrives in the cycle that would issue the final beat; abort must win, so no completion is reported. In the second, a flag clear is pulsed in the cycle where the final beat also sets the completion flag and the watermark. The bench provokes both by timing the control pulses against its own running beat count. It then judges the outcome from the beat total and the flag state read one cycle later.

// File: rtl/xfer2d_pkg.sv
package xfer2d_pkg;

    localparam int LINE_W = 16;
    localparam int PIX_W  = 14;
    localparam int LUT_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    localparam int FLAG_TC   = 0;
    localparam int FLAG_WM   = 1;
    localparam int NUM_FLAGS = 2;

    typedef struct packed {
        logic wm;
        logic tc;
    } flag_ev_t;

    function automatic logic is_active(seq_state_e s);
        return (s == ST_RUN) || (s == ST_SUSP);
    endfunction

endpackage

// File: rtl/xfer2d_fsm.sv
module xfer2d_fsm
    import xfer2d_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_set,
    input  logic       abort_set,
    input  logic       susp_req,
    input  logic       beat_ready,
    input  logic       job_end,
    output seq_state_e state_o,
    output logic       load,
    output logic       beat_go,
    output logic       finish
);

    seq_state_e state_q, state_d;

    always_comb begin
        load    = start_set && ((state_q == ST_IDLE) || (state_q == ST_DONE));
        beat_go = (state_q == ST_RUN) && !abort_set && !susp_req && beat_ready;
        finish  = beat_go && job_end;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: state_d = load ? ST_RUN : ST_IDLE;
            ST_RUN: begin
                if (abort_set)     state_d = ST_IDLE;
                else if (susp_req) state_d = ST_SUSP;
                else if (finish)   state_d = ST_DONE;
            end
            ST_SUSP: begin
                if (abort_set)      state_d = ST_IDLE;
                else if (!susp_req) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/xfer2d_walker.sv
module xfer2d_walker #(
    parameter int LINE_W = 16,
    parameter int PIX_W  = 14,
    parameter int LUT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic              lut_in,
    input  logic [LINE_W-1:0] lines_in,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic [LUT_W-1:0]  lut_cnt_in,
    input  logic [LINE_W-1:0] wm_in,
    output logic [LINE_W-1:0] line_idx,
    output logic [PIX_W-1:0]  pix_idx,
    output logic              line_end,
    output logic              job_end,
    output logic              wm_match
);

    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
    localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);

    logic              lut_q;
    logic [LINE_W-1:0] line_last_q, wm_q, line_q;
    logic [PIX_W-1:0]  pix_last_q, pix_q;

    always_comb begin
        line_end = (pix_q == pix_last_q);
        job_end  = line_end && (line_q == line_last_q);
        wm_match = !lut_q && line_end && (line_q == wm_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lut_q       <= 1'b0;
            line_last_q <= '0;
            pix_last_q  <= '0;
            wm_q        <= '0;
            line_q      <= '0;
            pix_q       <= '0;
        end else if (load) begin
            lut_q       <= lut_in;
            line_last_q <= lut_in ? '0 : (lines_in - LINE_ONE);
            pix_last_q  <= lut_in ? (PIX_W'(lut_cnt_in) - PIX_ONE) : (pix_in - PIX_ONE);
            wm_q        <= wm_in;
            line_q      <= '0;
            pix_q       <= '0;
        end else if (adv) begin
            if (job_end) begin
                line_q <= '0;
                pix_q  <= '0;
            end else if (line_end) begin
                line_q <= line_q + LINE_ONE;
                pix_q  <= '0;
            end else begin
                pix_q  <= pix_q + PIX_ONE;
            end
        end
    end

    assign line_idx = line_q;
    assign pix_idx  = pix_q;

endmodule

// File: rtl/xfer2d_flags.sv
module xfer2d_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] ie_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] irq_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)           bit_q <= 1'b0;
            else if (set_i[g]) bit_q <= 1'b1;
            else if (clr_i[g]) bit_q <= 1'b0;
        end
        assign flag_o[g] = bit_q;
        assign irq_o[g]  = bit_q & ie_i[g];
    end

endmodule

// File: rtl/xfer2d_seq.sv
module xfer2d_seq
    import xfer2d_pkg::*;
#(
    parameter int LINE_W = xfer2d_pkg::LINE_W,
    parameter int PIX_W  = xfer2d_pkg::PIX_W,
    parameter int LUT_W  = xfer2d_pkg::LUT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_set,
    input  logic              susp_req,
    input  logic              abort_set,
    input  logic              lut_job,
    input  logic [LINE_W-1:0] num_lines,
    input  logic [PIX_W-1:0]  line_pixels,
    input  logic [LUT_W-1:0]  lut_count,
    input  logic [LINE_W-1:0] wm_line,
    input  logic              tc_ie,
    input  logic              wm_ie,
    input  logic              clr_tc,
    input  logic              clr_wm,
    input  logic              beat_ready,
    output logic              beat_go,
    output logic [LINE_W-1:0] beat_line,
    output logic [PIX_W-1:0]  beat_pix,
    output logic              beat_eol,
    output logic              dp_hold,
    output logic              start_bit,
    output logic              busy,
    output logic              tc_flag,
    output logic              wm_flag,
    output logic              tc_irq,
    output logic              wm_irq
);

    seq_state_e state;
    logic       load, finish, job_end, wm_match;
    flag_ev_t   ev_set, ev_clr, ev_ie, ev_flag, ev_irq;

    xfer2d_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_set  (start_set),
        .abort_set  (abort_set),
        .susp_req   (susp_req),
        .beat_ready (beat_ready),
        .job_end    (job_end),
        .state_o    (state),
        .load       (load),
        .beat_go    (beat_go),
        .finish     (finish)
    );

    xfer2d_walker #(
        .LINE_W (LINE_W),
        .PIX_W  (PIX_W),
        .LUT_W  (LUT_W)
    ) u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .adv        (beat_go),
        .lut_in     (lut_job),
        .lines_in   (num_lines),
        .pix_in     (line_pixels),
        .lut_cnt_in (lut_count),
        .wm_in      (wm_line),
        .line_idx   (beat_line),
        .pix_idx    (beat_pix),
        .line_end   (beat_eol),
        .job_end    (job_end),
        .wm_match   (wm_match)
    );

    always_comb begin
        ev_set.tc = finish;
        ev_set.wm = beat_go && wm_match;
        ev_clr.tc = clr_tc;
        ev_clr.wm = clr_wm;
        ev_ie.tc  = tc_ie;
        ev_ie.wm  = wm_ie;
    end

    xfer2d_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ev_set),
        .clr_i  (ev_clr),
        .ie_i   (ev_ie),
        .flag_o (ev_flag),
        .irq_o  (ev_irq)
    );

    assign tc_flag   = ev_flag.tc;
    assign wm_flag   = ev_flag.wm;
    assign tc_irq    = ev_irq.tc;
    assign wm_irq    = ev_irq.wm;
    assign dp_hold   = (state == ST_SUSP);
    assign start_bit = is_active(state);
    assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/xfer2d_seq_chk.sv
module xfer2d_seq_chk #(
    parameter int LINE_W = 16,
    parameter int PIX_W  = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              abort_set,
    input logic              susp_req,
    input logic              tc_ie,
    input logic              wm_ie,
    input logic              clr_tc,
    input logic              clr_wm,
    input logic              beat_go,
    input logic [LINE_W-1:0] beat_line,
    input logic [PIX_W-1:0]  beat_pix,
    input logic              dp_hold,
    input logic              start_bit,
    input logic              busy,
    input logic              tc_flag,
    input logic              wm_flag,
    input logic              tc_irq,
    input logic              wm_irq
);

    assert_start_fall_sets_tc_R1: assert property (@(posedge clk) disable iff (rst)
        ($fell(start_bit) && !$past(abort_set)) |-> tc_flag);

    assert_tc_irq_gated_R2: assert property (@(posedge clk) disable iff (rst)
        tc_irq |-> (tc_flag && tc_ie));

    assert_susp_no_beat_R3: assert property (@(posedge clk) disable iff (rst)
        (susp_req || dp_hold) |-> !beat_go);

    assert_susp_hold_pos_R3: assert property (@(posedge clk) disable iff (rst)
        (dp_hold && $past(dp_hold)) |-> ($stable(beat_line) && $stable(beat_pix)));

    assert_abort_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (abort_set && start_bit) |=> (!start_bit && !busy));

    assert_abort_no_tc_R4: assert property (@(posedge clk) disable iff (rst)
        (abort_set && start_bit && !tc_flag) |=> !tc_flag);

    assert_beat_when_running_R6: assert property (@(posedge clk) disable iff (rst)
        beat_go |-> (start_bit && !dp_hold));

    assert_wm_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        wm_irq |-> (wm_flag && wm_ie));

    assert_tc_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (tc_flag && !clr_tc) |=> tc_flag);

    assert_wm_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (wm_flag && !clr_wm) |=> wm_flag);

endmodule

bind xfer2d_seq xfer2d_seq_chk #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .abort_set (abort_set),
    .susp_req  (susp_req),
    .tc_ie     (tc_ie),
    .wm_ie     (wm_ie),
    .clr_tc    (clr_tc),
    .clr_wm    (clr_wm),
    .beat_go   (beat_go),
    .beat_line (beat_line),
    .beat_pix  (beat_pix),
    .dp_hold   (dp_hold),
    .start_bit (start_bit),
    .busy      (busy),
    .tc_flag   (tc_flag),
    .wm_flag   (wm_flag),
    .tc_irq    (tc_irq),
    .wm_irq    (wm_irq)
);

// File: tb/xfer2d_seq_tb.sv
`timescale 1ns/1ps
module xfer2d_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_set = 0, susp_req = 0, abort_set = 0, lut_job = 0;
    logic [15:0] num_lines = 16'd1, wm_line = 16'd0;
    logic [13:0] line_pixels = 14'd1;
    logic [7:0]  lut_count = 8'd1;
    logic        tc_ie = 0, wm_ie = 0, clr_tc = 0, clr_wm = 0, beat_ready = 0;
    logic        beat_go, beat_eol, dp_hold, start_bit, busy;
    logic        tc_flag, wm_flag, tc_irq, wm_irq;
    logic [15:0] beat_line;
    logic [13:0] beat_pix;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    xfer2d_seq dut_i (
        .clk(clk), .rst(rst), .start_set(start_set), .susp_req(susp_req),
        .abort_set(abort_set), .lut_job(lut_job), .num_lines(num_lines),
        .line_pixels(line_pixels), .lut_count(lut_count), .wm_line(wm_line),
        .tc_ie(tc_ie), .wm_ie(wm_ie), .clr_tc(clr_tc), .clr_wm(clr_wm),
        .beat_ready(beat_ready), .beat_go(beat_go), .beat_line(beat_line),
        .beat_pix(beat_pix), .beat_eol(beat_eol), .dp_hold(dp_hold),
        .start_bit(start_bit), .busy(busy), .tc_flag(tc_flag), .wm_flag(wm_flag),
        .tc_irq(tc_irq), .wm_irq(wm_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Runs one job. Inputs are driven just after a falling edge; the combinational
    // beat outputs are observed 1 ns later, registered outputs after the next falling edge.
    task automatic run_job(input int L, input int P, input int wm, input bit lut,
                           input int lutn, input bit stall, input int susp_at,
                           input int abort_at, input bit abort_in_susp,
                           input bit restart, input bit clr_end, input bit keep);
        int  total, beats, wm_first, cyc, scnt, exp_line, exp_pix, exp_wm, last_pix;
        bit  bad_order, bad_hold, aborted;
        total = lut ? lutn : L * P;
        last_pix = lut ? lutn - 1 : P - 1;
        beats = 0; wm_first = -1; cyc = 0; scnt = 0;
        bad_order = 0; bad_hold = 0; aborted = 0;
        num_lines = 16'(L); line_pixels = 14'(P); wm_line = 16'(wm);
        lut_job = lut; lut_count = 8'(lutn);
        if (!keep) begin
            clr_tc = 1; clr_wm = 1;
            @(negedge clk);
            clr_tc = 0; clr_wm = 0;
        end
        start_set = 1;
        @(negedge clk);
        start_set = 0;
        chk(start_bit && busy, "R1", "start_bit/busy after launch", {start_bit, busy}, 3);
        while (1) begin
            exp_line = lut ? 0 : beats / P;
            exp_pix  = lut ? beats : beats % P;
            beat_ready = !stall || (cyc % 3 != 1);
            susp_req = 0;
            if (susp_at >= 0 && beats == susp_at && !aborted &&
                (abort_in_susp || scnt < 4)) begin
                susp_req = 1;
                scnt++;
            end
            abort_set = (abort_at >= 0 && !aborted && beats == abort_at &&
                         (!abort_in_susp || dp_hold));
            if (abort_set) aborted = 1;
            start_set = restart && (cyc == 2);
            clr_tc = clr_end && (beats == total - 1);
            clr_wm = clr_end && (beats == total - 1);
            #1;
            if (dp_hold && (int'(beat_line) != exp_line || int'(beat_pix) != exp_pix))
                bad_hold = 1;
            if (beat_go) begin
                if (susp_req || abort_set || !beat_ready) bad_order = 1;
                if (int'(beat_line) != exp_line || int'(beat_pix) != exp_pix) bad_order = 1;
                if (beat_eol != (exp_pix == last_pix)) bad_order = 1;
                beats++;
            end
            @(negedge clk);
            abort_set = 0; start_set = 0; clr_tc = 0; clr_wm = 0;
            cyc++;
            if (wm_flag && wm_first < 0 && !keep) wm_first = beats;
            if (!start_bit || cyc > 4000) break;
        end
        susp_req = 0;
        beat_ready = 0;
        chk(!bad_order, "R6", "beat order/eol/ready gating", bad_order, 0);
        if (susp_at >= 0)
            chk(!bad_hold, "R3", "position held while suspended", bad_hold, 0);
        if (abort_at >= 0) begin
            chk(!busy && !start_bit, "R4", "idle right after abort", {busy, start_bit}, 0);
            chk(!tc_flag, "R4", "no completion after abort", tc_flag, 0);
            chk(beats == abort_at, "R4", "beats before abort", beats, abort_at);
        end else begin
            chk(beats == total, lut ? "R5" : "R6", "beat total", beats, total);
            chk(tc_flag, "R1", "tc_flag at final edge", tc_flag, 1);
            chk(busy, "R1", "busy one cycle past end", busy, 1);
            @(negedge clk);
            chk(!busy, "R1", "busy dropped", busy, 0);
        end
        if (!keep) begin
            exp_wm = (!lut && wm < L && (abort_at < 0 || abort_at >= (wm + 1) * P))
                     ? (wm + 1) * P : -1;
            chk(wm_first == exp_wm, lut ? "R5" : "R7", "watermark beat", wm_first, exp_wm);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !start_bit && !tc_flag && !wm_flag && !beat_go && !dp_hold,
            "R1", "reset state", {busy, start_bit, tc_flag, wm_flag, beat_go, dp_hold}, 0);

        // R6 R7: sweep of line count, line length and watermark line
        for (int l = 1; l <= 3; l++)
            for (int p = 1; p <= 3; p++)
                for (int w = 0; w <= 3; w++)
                    run_job(l, p, w, 0, 1, (w % 2) == 1, -1, -1, 0, 0, 0, 0);

        // R3: suspend mid-job then resume, with and without ready stalls
        run_job(3, 3, 1, 0, 1, 0, 4, -1, 0, 0, 0, 0);
        run_job(2, 4, 0, 0, 1, 1, 3, -1, 0, 0, 0, 0);
        // R3 R4: suspend/abort in the cycle that would issue the final beat
        run_job(2, 2, 1, 0, 1, 0, 3, -1, 0, 0, 0, 0);
        run_job(2, 2, 1, 0, 1, 0, -1, 3, 0, 0, 0, 0);
        // R4: abort while running and while suspended
        run_job(3, 3, 2, 0, 1, 0, -1, 4, 0, 0, 0, 0);
        run_job(3, 3, 0, 0, 1, 0, 5, 5, 1, 0, 0, 0);

        // R5: table loads, plain, suspended, aborted in suspend
        run_job(1, 1, 0, 1, 6, 1, -1, -1, 0, 0, 0, 0);
        run_job(1, 1, 0, 1, 5, 0, 2, -1, 0, 0, 0, 0);
        run_job(1, 1, 0, 1, 7, 0, 3, 3, 1, 0, 0, 0);

        // R10: start pulse during a job is ignored
        run_job(2, 3, 0, 0, 1, 0, -1, -1, 0, 1, 0, 0);

        // R9: clear in the same cycle as final-beat set, set wins
        run_job(2, 2, 1, 0, 1, 0, -1, -1, 0, 0, 1, 0);
        chk(tc_flag && wm_flag, "R9", "set wins over clear", {tc_flag, wm_flag}, 3);

        // R9: flags survive a new job that does not set them
        run_job(2, 2, 0, 0, 1, 0, -1, -1, 0, 0, 0, 0);
        clr_tc = 1;
        @(negedge clk);
        clr_tc = 0;
        chk(!tc_flag && wm_flag, "R9", "clr_tc clears only tc", {tc_flag, wm_flag}, 1);
        run_job(2, 2, 7, 0, 1, 0, -1, 0, 0, 0, 0, 1);
        chk(wm_flag, "R9", "wm_flag kept across new job", wm_flag, 1);

        // R2 R8: interrupt gating
        run_job(3, 2, 1, 0, 1, 0, -1, -1, 0, 0, 0, 0);
        tc_ie = 0; wm_ie = 0;
        #1;
        chk(!tc_irq && !wm_irq, "R2", "irqs masked", {tc_irq, wm_irq}, 0);
        tc_ie = 1;
        #1;
        chk(tc_irq && !wm_irq, "R2", "tc_irq enabled", {tc_irq, wm_irq}, 2);
        tc_ie = 0; wm_ie = 1;
        #1;
        chk(!tc_irq && wm_irq, "R8", "wm_irq enabled", {tc_irq, wm_irq}, 1);
        @(negedge clk);
        clr_wm = 1;
        @(negedge clk);
        clr_wm = 0;
        chk(!wm_flag && !wm_irq, "R8", "wm_irq follows cleared flag", {wm_flag, wm_irq}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule